// File: doc/BRIEF.md
# PCI Base Address Register File

This block holds the base address registers of one PCI configuration header. Each slot has a configuration mask, given as a parameter. The mask fixes which address bits software may write and what kind of window the slot describes. The kinds are: a 16-bit or 32-bit I/O window, or a memory window that must sit below 1 MiB, anywhere in 32 bits, or anywhere in 64 bits. The kind of every slot is worked out once, while reset is held, and kept in a register. It is never derived again on a later write.

Configuration writes arrive with a slot index, a data word and byte lane enables. Every write takes the same masked path, including the all-ones write that firmware uses to size a window. A read returns the stored address bits together with the fixed kind bits, so the sizing readback shows the window size. A 64-bit memory window uses two neighbouring slots. The second slot holds the upper 32 address bits.

Each slot drives a registered decoded base address and a one-cycle change pulse. The pulse fires only when the decoded base really differs from the base held before. Host logic uses it to move the address window.

Top module: `pci_bar_file`

## Requirements
- R1: While reset is asserted and after it is released, every slot reads back only its fixed kind bits, every decoded base is zero and no change pulse is raised.
- R2: The low read bits encode the kind and no write can alter them. I/O reads bit 0 = 1 and bit 1 = 0. Memory reads bit 0 = 0 with bits 2:1 equal to 00 for 32-bit, 01 for below 1 MiB and 10 for 64-bit, and bit 3 = 0. The upper slot of a 64-bit pair has no kind bits.
- R3: A write changes only the bits that its slot's mask makes writable. All other bits read as the kind bits, and a slot keeps its value when it is not written.
- R4: Writing 0xFFFFFFFF to a slot makes it read back its writable mask ORed with its kind bits. With the default masks, slot 0 (mask 0xFFFE0000) then reads 0xFFFE0000, which describes a 128 KiB window.
- R5: A 16-bit I/O slot always holds zero in bits 31:16. A below-1 MiB memory slot always holds zero in bits 31:20.
- R6: A memory slot whose mask has bits 2:1 = 10 pairs with the next slot. The next slot's 32 bits are writable as its own mask allows. The low slot's decoded base is {next slot, low slot without kind bits}. The upper slot's own decoded base stays zero and never pulses.
- R7: One cycle after a write, a slot's decoded base output is updated. Its change pulse is high for that one cycle only if the new base differs from the held one. A write to the upper half of a pair pulses the low slot.
- R8: Only byte lanes whose enable is 1 are written (enable bit n covers data bits 8n+7:8n).
- R9: A read request returns the addressed slot's readback value on the data output on the next cycle. An index beyond the last slot reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the slot kinds are decided while it is held |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | IDX_W | Slot written |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte lane enables |
| rd_en | input | 1 | Configuration read strobe |
| rd_idx | input | IDX_W | Slot read |
| rd_data | output | 32 | Registered readback value |
| base_o | output | NUM_BARS*64 | Decoded base per slot, 64 bits each, slot 0 lowest |
| chg_o | output | NUM_BARS | One-cycle change pulse per slot |

## Verification
The hardest case to reach is a change pulse that arrives through the wrong slot. A write to the upper half of a 64-bit pair must pulse the lower slot, and the upper slot must stay silent. The stimulus gets there by first loading the lower slot and then sweeping walking ones and byte-lane patterns across the upper slot. Each write also checks the full pulse vector. Repeated writes of an unchanged value follow each sizing write, to show that a pulse needs a real change of the decoded base.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;

  localparam int BAR_W  = 32;
  localparam int LANES  = BAR_W / 8;
  localparam int BASE_W = 2 * BAR_W;

  typedef enum logic [2:0] {
    BK_IO16,
    BK_IO32,
    BK_MEM20,
    BK_MEM32,
    BK_MEM64,
    BK_UPPER
  } bar_kind_e;

  // Kind of one slot from its own mask and whether the slot below opened a pair.
  function automatic bar_kind_e kind_of(input logic [BAR_W-1:0] m,
                                        input logic below_is_pair,
                                        input logic has_next);
    if (below_is_pair)                  return BK_UPPER;
    if (m[0])                           return (m[31:16] == '0) ? BK_IO16 : BK_IO32;
    if (m[2:1] == 2'b10 && has_next)    return BK_MEM64;
    if (m[2:1] == 2'b01)                return BK_MEM20;
    return BK_MEM32;
  endfunction

  // Writable address bits for a slot kind.
  function automatic logic [BAR_W-1:0] writable(input bar_kind_e k,
                                                input logic [BAR_W-1:0] m);
    case (k)
      BK_IO16:  return m & 32'h0000_FFFC;
      BK_IO32:  return m & 32'hFFFF_FFFC;
      BK_MEM20: return m & 32'h000F_FFF0;
      BK_UPPER: return m;
      default:  return m & 32'hFFFF_FFF0;
    endcase
  endfunction

  // Read-only kind bits returned on readback.
  function automatic logic [BAR_W-1:0] kind_bits(input bar_kind_e k);
    case (k)
      BK_IO16, BK_IO32: return 32'h1;
      BK_MEM20:         return 32'h2;
      BK_MEM64:         return 32'h4;
      default:          return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/pci_bar_slot.sv
module pci_bar_slot
  import pci_bar_pkg::*;
#(
  parameter logic [BAR_W-1:0] MASK = 32'hFFFF_0000,
  parameter bar_kind_e        KIND = BK_MEM32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BAR_W-1:0] wr_data,
  input  logic [LANES-1:0] wr_be,
  output logic [BAR_W-1:0] addr_o,
  output logic [BAR_W-1:0] rd_o
);

  bar_kind_e        kind_q;
  logic [BAR_W-1:0] wmask_q;
  logic [BAR_W-1:0] kbits_q;
  logic [BAR_W-1:0] bar_q;
  logic [BAR_W-1:0] lane_m;

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      lane_m[b*8 +: 8] = wr_be[b] ? wmask_q[b*8 +: 8] : 8'h00;
    end
  end

  // The kind and its masks are captured once while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= KIND;
      wmask_q <= writable(KIND, MASK);
      kbits_q <= kind_bits(KIND);
      bar_q   <= '0;
    end else if (wr_en) begin
      bar_q <= (bar_q & ~lane_m) | (wr_data & lane_m);
    end
  end

  assign addr_o = bar_q;
  assign rd_o   = bar_q | kbits_q;

  p_kind_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(kind_q) && $stable(kbits_q));

  p_in_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (bar_q & ~wmask_q) == '0);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bar_q));

  p_narrow_hi_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (kind_q == BK_IO16 || kind_q == BK_MEM20) |-> bar_q[31:20] == '0);

  p_io16_hi_zero_r5: assert property (@(posedge clk) disable iff (rst)
    kind_q == BK_IO16 |-> bar_q[19:16] == '0);

endmodule

// File: rtl/pci_bar_notify.sv
module pci_bar_notify
  import pci_bar_pkg::*;
#(
  parameter int AW = BASE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] base_o,
  output logic          chg_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
      chg_o  <= 1'b0;
    end else begin
      chg_o <= (base_i != base_o);
      if (base_i != base_o) base_o <= base_i;
    end
  end

  p_pulse_on_change_r7: assert property (@(posedge clk) disable iff (rst)
    chg_o |-> base_o != $past(base_o));

  p_quiet_when_same_r7: assert property (@(posedge clk) disable iff (rst)
    !chg_o |-> base_o == $past(base_o));

endmodule

// File: rtl/pci_bar_file.sv
module pci_bar_file
  import pci_bar_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS-1:0][BAR_W-1:0] MASKS = {
    32'h000F_F002,  // slot 5: memory below 1 MiB, 4 KiB
    32'h0000_FFF1,  // slot 4: 16-bit I/O, 16 bytes
    32'hFFFF_FF01,  // slot 3: 32-bit I/O, 256 bytes
    32'hFFFF_FFFF,  // slot 2: upper half of slot 1
    32'hFFFF_F004,  // slot 1: 64-bit memory, 4 KiB
    32'hFFFE_0000   // slot 0: 32-bit memory, 128 KiB
  },
  localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BAR_W-1:0]           wr_data,
  input  logic [LANES-1:0]           wr_be,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [BAR_W-1:0]           rd_data,
  output logic [NUM_BARS*BASE_W-1:0] base_o,
  output logic [NUM_BARS-1:0]        chg_o
);

  // Walks the slots from the bottom so a pair claims the slot above it.
  function automatic bar_kind_e slot_kind(input int idx);
    bar_kind_e k;
    logic      pair_open;
    k = BK_MEM32;
    pair_open = 1'b0;
    for (int s = 0; s < NUM_BARS; s++) begin
      k = kind_of(MASKS[s], pair_open, s < NUM_BARS - 1);
      pair_open = (k == BK_MEM64);
      if (s == idx) return k;
    end
    return k;
  endfunction

  logic [NUM_BARS-1:0][BAR_W-1:0] addr_v;
  logic [NUM_BARS-1:0][BAR_W-1:0] rd_v;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
    localparam bar_kind_e K = slot_kind(i);
    logic [BASE_W-1:0] base_next;

    pci_bar_slot #(.MASK(MASKS[i]), .KIND(K)) slot_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en && wr_idx == IDX_W'(i)),
      .wr_data (wr_data),
      .wr_be   (wr_be),
      .addr_o  (addr_v[i]),
      .rd_o    (rd_v[i])
    );

    if (K == BK_UPPER) begin : g_up
      assign base_next = '0;
    end else if (K == BK_MEM64) begin : g_pair
      assign base_next = {addr_v[i+1], addr_v[i]};
    end else begin : g_single
      assign base_next = {{(BASE_W-BAR_W){1'b0}}, addr_v[i]};
    end

    pci_bar_notify #(.AW(BASE_W)) notify_i (
      .clk    (clk),
      .rst    (rst),
      .base_i (base_next),
      .base_o (base_o[i*BASE_W +: BASE_W]),
      .chg_o  (chg_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= (int'(rd_idx) < NUM_BARS) ? rd_v[rd_idx] : '0;
    end
  end

  p_oob_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en && int'(rd_idx) >= NUM_BARS |=> rd_data == '0);

  p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/pci_bar_file_tb_top.sv
module pci_bar_file_tb_top;

  localparam int N   = 6;
  localparam int IW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic          rd_en = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [31:0]   rd_data;
  logic [N*64-1:0] base_o;
  logic [N-1:0]  chg_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_bar_file dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .base_o(base_o), .chg_o(chg_o)
  );

  // Expected writable masks and kind bits for the default masks (R2, R5, R6).
  logic [31:0] wm [N] = '{32'hFFFE_0000, 32'hFFFF_F000, 32'hFFFF_FFFF,
                          32'hFFFF_FF00, 32'h0000_FFF0, 32'h000F_F000};
  logic [31:0] kb [N] = '{32'h0, 32'h4, 32'h0, 32'h1, 32'h1, 32'h2};
  logic [31:0] mdl [N];

  function automatic logic [63:0] exp_base(input int s);
    if (s == 2) return 64'h0;
    if (s == 1) return {mdl[2], mdl[1]};
    return {32'h0, mdl[s]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_check(input int s, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = IW'(s);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {32'h0, rd_data}, {32'h0, mdl[s] | kb[s]});
  endtask

  // One write, then readback, decoded base and pulse vector.
  task automatic wr(input int s, input logic [31:0] d, input logic [3:0] be, input string req);
    logic [31:0] lm;
    logic [63:0] old_b [N];
    logic [N-1:0] exp_chg;
    for (int j = 0; j < N; j++) old_b[j] = exp_base(j);
    for (int b = 0; b < 4; b++) lm[b*8 +: 8] = be[b] ? wm[s][b*8 +: 8] : 8'h00;
    mdl[s] = (mdl[s] & ~lm) | (d & lm);
    exp_chg = '0;
    for (int j = 0; j < N; j++) exp_chg[j] = (exp_base(j) != old_b[j]);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(s); wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b1; rd_idx = IW'(s);
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " readback"}, {32'h0, rd_data}, {32'h0, mdl[s] | kb[s]});
    chk("R7 pulse vector", {{(64-N){1'b0}}, chg_o}, {{(64-N){1'b0}}, exp_chg});
    for (int j = 0; j < N; j++) chk("R6/R7 decoded base", base_o[j*64 +: 64], exp_base(j));
    @(negedge clk);
    chk("R7 pulse drops", {{(64-N){1'b0}}, chg_o}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < N; s++) mdl[s] = '0;
    repeat (3) @(negedge clk);
    // R1: the reset state is checked while reset is still held.
    chk("R1 base in reset", base_o[63:0], 64'h0);
    chk("R1 pulse in reset", {{(64-N){1'b0}}, chg_o}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    // R1: state after reset release.
    for (int s = 0; s < N; s++) rd_check(s, "R1 reset readback");
    for (int s = 0; s < N; s++) chk("R1 reset base", base_o[s*64 +: 64], 64'h0);
    chk("R1 no pulse", {{(64-N){1'b0}}, chg_o}, 64'h0);
    // R9: an index past the last slot reads zero.
    @(negedge clk); rd_en = 1'b1; rd_idx = 3'd7;
    @(negedge clk); rd_en = 1'b0;
    chk("R9 out of range read", {32'h0, rd_data}, 64'h0);

    for (int s = 0; s < N; s++) begin
      wr(s, 32'h0, 4'hF, "R7 zero write");
      wr(s, 32'hFFFF_FFFF, 4'hF, "R4 sizing");
      chk("R4 sizing value", {32'h0, mdl[s] | kb[s]}, {32'h0, wm[s] | kb[s]});
      wr(s, 32'hFFFF_FFFF, 4'hF, "R7 repeat sizing");
      for (int k = 0; k < 32; k++) wr(s, 32'h1 << k, 4'hF, "R3/R5 walking one");
      wr(s, 32'hFFFF_FFF0, 4'hF, "R2 kind bits kept");
      for (int be = 0; be < 16; be++) wr(s, 32'hA5C3_5A3C ^ (be * 32'h1111_1111), be[3:0], "R8 lanes");
      for (int j = 0; j < N; j++) rd_check(j, "R3 other slots unchanged");
    end
    // R6: load the low half, then sweep the upper half of the pair.
    wr(1, 32'h8000_0000, 4'hF, "R6 low half");
    for (int k = 0; k < 32; k++) wr(2, 32'h1 << k, 4'hF, "R6 upper half");
    wr(2, 32'h1234_5678, 4'h5, "R6/R8 upper lanes");
    wr(2, 32'h1234_5678, 4'h5, "R6/R7 upper repeat");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule